// File: doc/BRIEF.md
# GPIO Output Control Bank

This block controls the output side of a bank of general-purpose I/O lines. Each line has five control states: owner, output enable, output data, direct-write mask and open-drain. Software changes each state with a write to a set register or a clear register, and reads it back through a status register. Two selection registers together give each line a 2-bit code. When the controller does not own a line, the code picks which of four peripheral sources drives it.

For each line the block produces a pad output value and a pad output enable. The source is either the controller's own data and enable states or the selected peripheral's data and enable. Open-drain mode is applied after that choice. The data register also accepts a direct write, so some lines can be raised and others lowered in one bus access, limited to the lines whose mask bit is set. The block returns the pad input levels to software through a two-flop synchronizer.

The bus has single-cycle writes. Reads are combinational from the address while the read strobe is high.

Top module: `gpo_bank`

## Requirements
- R1: After reset, every readable register reads 0: owner, enable, data, mask and open-drain status, and both selection registers.
- R2: In the owner (0x00 set, 0x01 clear), enable (0x03/0x04), data (0x06/0x07), mask (0x09/0x0A) and open-drain (0x0C/0x0D) set/clear pairs, a 1 sets or clears the matching status bit and a 0 leaves it unchanged. The status reads back at 0x02, 0x05, 0x08, 0x0B and 0x0E.
- R3: A write to the data status address 0x08 changes only the bits whose mask status bit is 1. All other data bits keep their value, so with the mask at 0 the write has no effect.
- R4: A line whose owner bit is 1 drives padOut from its data status bit and padOe from its enable status bit. A line whose owner bit is 0 takes both from the peripheral selected by the code {selHi, selLo}: 0 selects A (periphDout[0]), 1 selects B, 2 selects C and 3 selects D.
- R5: Set and clear writes to enable and data update their status while the peripheral owns the line. The stored values drive the line as soon as ownership passes to the controller.
- R6: On a line whose open-drain bit is 1, padOut is 0 and padOe is 1 only when the source enable is 1 and the source level is 0. This holds under both controller and peripheral ownership.
- R7: The selection registers (low bit at 0x0F, high bit at 0x10) are plain read/write. Set and clear addresses, and unmapped addresses, read 0. busRdData is 0 when busRdEn is 0.
- R8: The pin status register (0x11) returns padIn delayed by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous |
| busWrEn | input | 1 | Write strobe, one write per cycle |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | 5 | Word address |
| busWrData | input | 32 | Write data, one bit per line |
| busRdData | output | 32 | Read data |
| periphDout | input | 4x32 | Peripheral data, index 0..3 = A..D |
| periphOe | input | 4x32 | Peripheral output enables, index 0..3 = A..D |
| padIn | input | 32 | Pad input levels |
| padOut | output | 32 | Pad output value |
| padOe | output | 32 | Pad output enable |

## Verification
On every cycle the assertions check that a decoded write raises at most one strobe, and that set and clear writes take effect on the bits written. They also check that a direct data write leaves unmasked bits alone, that status holds when no write occurs, and that an owned open-drain line holding a 1 never drives. They further check that the pin status follows padIn two edges later. Only the bench scenarios can show the full source selection for all four peripheral codes in combination with ownership and open-drain. The same applies to configuring a line before it is taken over and to the read-side map.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] ADR_OWN_SET = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_OWN_CLR = 5'h01;
  localparam logic [ADDR_W-1:0] ADR_OWN_STA = 5'h02;
  localparam logic [ADDR_W-1:0] ADR_OE_SET  = 5'h03;
  localparam logic [ADDR_W-1:0] ADR_OE_CLR  = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_OE_STA  = 5'h05;
  localparam logic [ADDR_W-1:0] ADR_DAT_SET = 5'h06;
  localparam logic [ADDR_W-1:0] ADR_DAT_CLR = 5'h07;
  localparam logic [ADDR_W-1:0] ADR_DAT_STA = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_MSK_SET = 5'h09;
  localparam logic [ADDR_W-1:0] ADR_MSK_CLR = 5'h0A;
  localparam logic [ADDR_W-1:0] ADR_MSK_STA = 5'h0B;
  localparam logic [ADDR_W-1:0] ADR_OD_SET  = 5'h0C;
  localparam logic [ADDR_W-1:0] ADR_OD_CLR  = 5'h0D;
  localparam logic [ADDR_W-1:0] ADR_OD_STA  = 5'h0E;
  localparam logic [ADDR_W-1:0] ADR_SEL_LO  = 5'h0F;
  localparam logic [ADDR_W-1:0] ADR_SEL_HI  = 5'h10;
  localparam logic [ADDR_W-1:0] ADR_PIN_STA = 5'h11;

  typedef struct packed {
    logic ownSet;
    logic ownClr;
    logic oeSet;
    logic oeClr;
    logic datSet;
    logic datClr;
    logic datWr;
    logic mskSet;
    logic mskClr;
    logic odSet;
    logic odClr;
    logic selLoWr;
    logic selHiWr;
  } gpo_strobe_t;
endpackage

// File: rtl/gpo_ctrl.sv
module gpo_ctrl
  import gpo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output gpo_strobe_t       stb
);
  always_comb begin
    stb = '0;
    if (busWrEn) begin
      case (busAddr)
        ADR_OWN_SET: stb.ownSet  = 1'b1;
        ADR_OWN_CLR: stb.ownClr  = 1'b1;
        ADR_OE_SET:  stb.oeSet   = 1'b1;
        ADR_OE_CLR:  stb.oeClr   = 1'b1;
        ADR_DAT_SET: stb.datSet  = 1'b1;
        ADR_DAT_CLR: stb.datClr  = 1'b1;
        ADR_DAT_STA: stb.datWr   = 1'b1;
        ADR_MSK_SET: stb.mskSet  = 1'b1;
        ADR_MSK_CLR: stb.mskClr  = 1'b1;
        ADR_OD_SET:  stb.odSet   = 1'b1;
        ADR_OD_CLR:  stb.odClr   = 1'b1;
        ADR_SEL_LO:  stb.selLoWr = 1'b1;
        ADR_SEL_HI:  stb.selHiWr = 1'b1;
        default:     stb = '0;
      endcase
    end
  end

  // R2: one access touches at most one state
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));
  // R2: no write strobe, no state change request
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> (stb == '0));
endmodule

// File: rtl/gpo_datapath.sv
module gpo_datapath
  import gpo_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int NUM_SRC  = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  gpo_strobe_t                       stb,
  input  logic [NUM_PINS-1:0]               wrData,
  input  logic                              rdEn,
  input  logic [ADDR_W-1:0]                 rdAddr,
  output logic [NUM_PINS-1:0]               rdData,
  input  logic [NUM_SRC-1:0][NUM_PINS-1:0]  periphDout,
  input  logic [NUM_SRC-1:0][NUM_PINS-1:0]  periphOe,
  input  logic [NUM_PINS-1:0]               padIn,
  output logic [NUM_PINS-1:0]               padOut,
  output logic [NUM_PINS-1:0]               padOe
);
  localparam int SEL_W = $clog2(NUM_SRC);

  logic [NUM_PINS-1:0] ownStat, oeStat, datStat, mskStat, odStat;
  logic [NUM_PINS-1:0] selLo, selHi, syncA, pinStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownStat <= '0; oeStat <= '0; datStat <= '0;
      mskStat <= '0; odStat <= '0; selLo <= '0; selHi <= '0;
      syncA   <= '0; pinStat <= '0;
    end else begin
      if (stb.ownSet)  ownStat <= ownStat | wrData;
      if (stb.ownClr)  ownStat <= ownStat & ~wrData;
      if (stb.oeSet)   oeStat  <= oeStat | wrData;
      if (stb.oeClr)   oeStat  <= oeStat & ~wrData;
      if (stb.datSet)  datStat <= datStat | wrData;
      if (stb.datClr)  datStat <= datStat & ~wrData;
      if (stb.datWr)   datStat <= (datStat & ~mskStat) | (wrData & mskStat);
      if (stb.mskSet)  mskStat <= mskStat | wrData;
      if (stb.mskClr)  mskStat <= mskStat & ~wrData;
      if (stb.odSet)   odStat  <= odStat | wrData;
      if (stb.odClr)   odStat  <= odStat & ~wrData;
      if (stb.selLoWr) selLo   <= wrData;
      if (stb.selHiWr) selHi   <= wrData;
      syncA   <= padIn;
      pinStat <= syncA;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SEL_W-1:0] code;
    logic srcLvl, srcEn;
    assign code   = {selHi[p], selLo[p]};
    assign srcLvl = ownStat[p] ? datStat[p] : periphDout[code][p];
    assign srcEn  = ownStat[p] ? oeStat[p]  : periphOe[code][p];
    assign padOut[p] = odStat[p] ? 1'b0 : srcLvl;
    assign padOe[p]  = odStat[p] ? (srcEn & ~srcLvl) : srcEn;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (rdAddr)
        ADR_OWN_STA: rdData = ownStat;
        ADR_OE_STA:  rdData = oeStat;
        ADR_DAT_STA: rdData = datStat;
        ADR_MSK_STA: rdData = mskStat;
        ADR_OD_STA:  rdData = odStat;
        ADR_SEL_LO:  rdData = selLo;
        ADR_SEL_HI:  rdData = selHi;
        ADR_PIN_STA: rdData = pinStat;
        default:     rdData = '0;
      endcase
    end
  end

  // Cycles since reset, saturating, for the synchronizer check
  logic [1:0] ageCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ageCnt <= '0;
    else if (ageCnt != 2'd2) ageCnt <= ageCnt + 2'd1;
  end

  a_r2_oe_set_takes: assert property (@(posedge clk) disable iff (!rstN)
    stb.oeSet |=> ((oeStat & $past(wrData)) == $past(wrData)));
  a_r2_oe_clr_takes: assert property (@(posedge clk) disable iff (!rstN)
    stb.oeClr |=> ((oeStat & $past(wrData)) == '0));
  a_r3_masked_write: assert property (@(posedge clk) disable iff (!rstN)
    stb.datWr |=> (((datStat ^ $past(datStat)) & ~$past(mskStat)) == '0));
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stb == '0) |=> ($stable(oeStat) && $stable(datStat) && $stable(odStat)));
  a_r6_od_release: assert property (@(posedge clk) disable iff (!rstN)
    ((odStat & ownStat & datStat & padOe) == '0));
  a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt == 2'd2) |-> (pinStat == $past(padIn, 2)));
endmodule

// File: rtl/gpo_bank.sv
module gpo_bank
  import gpo_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busWrEn,
  input  logic                        busRdEn,
  input  logic [4:0]                  busAddr,
  input  logic [NUM_PINS-1:0]         busWrData,
  output logic [NUM_PINS-1:0]         busRdData,
  input  logic [3:0][NUM_PINS-1:0]    periphDout,
  input  logic [3:0][NUM_PINS-1:0]    periphOe,
  input  logic [NUM_PINS-1:0]         padIn,
  output logic [NUM_PINS-1:0]         padOut,
  output logic [NUM_PINS-1:0]         padOe
);
  gpo_strobe_t stb;

  gpo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .stb(stb)
  );

  gpo_datapath #(.NUM_PINS(NUM_PINS), .NUM_SRC(4)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData),
    .rdEn(busRdEn), .rdAddr(busAddr), .rdData(busRdData),
    .periphDout(periphDout), .periphOe(periphOe),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: tb/sim_gpo_bank.sv
module sim_gpo_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [4:0] busAddr = '0;
  logic [NP-1:0] busWrData = '0, busRdData;
  logic [3:0][NP-1:0] periphDout = '0, periphOe = '0;
  logic [NP-1:0] padIn = '0, padOut, padOe;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [NP-1:0] mOwn = '0, mOe = '0, mDat = '0, mMsk = '0, mOd = '0, mLo = '0, mHi = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpo_bank u0 (.*);

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
    case (a)
      5'h00: mOwn |= d;  5'h01: mOwn &= ~d;
      5'h03: mOe  |= d;  5'h04: mOe  &= ~d;
      5'h06: mDat |= d;  5'h07: mDat &= ~d;
      5'h08: mDat = (mDat & ~mMsk) | (d & mMsk);
      5'h09: mMsk |= d;  5'h0A: mMsk &= ~d;
      5'h0C: mOd  |= d;  5'h0D: mOd  &= ~d;
      5'h0F: mLo = d;    5'h10: mHi = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [4:0] a, output logic [NP-1:0] d);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [4:0] a, input logic [NP-1:0] exp);
    logic [NP-1:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic padChk(input string req);
    logic [NP-1:0] eOut, eOe;
    for (int i = 0; i < NP; i++) begin
      logic lvl, en;
      int code;
      code = {mHi[i], mLo[i]};
      lvl = mOwn[i] ? mDat[i] : periphDout[code][i];
      en  = mOwn[i] ? mOe[i]  : periphOe[code][i];
      eOut[i] = mOd[i] ? 1'b0 : lvl;
      eOe[i]  = mOd[i] ? (en & ~lvl) : en;
    end
    #1;
    chk({req, " padOut"}, padOut, eOut);
    chk({req, " padOe"}, padOe, eOe);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 32; a++) rdChk("R1 reset read", 5'(a), '0);
    padChk("R1 reset pads");

    // R2: set/clear pairs, zeros ignored
    wr(5'h00, 32'hF0F0_1234); wr(5'h00, 32'h0000_0000); rdChk("R2 own set", 5'h02, mOwn);
    wr(5'h01, 32'h1000_0004); rdChk("R2 own clr", 5'h02, mOwn);
    wr(5'h03, 32'hAAAA_5555); wr(5'h04, 32'h0000_000F); rdChk("R2 oe", 5'h05, mOe);
    wr(5'h06, 32'h1357_9BDF); wr(5'h07, 32'h0003_0000); rdChk("R2 dat", 5'h08, mDat);
    wr(5'h09, 32'h0F0F_0F0F); wr(5'h0A, 32'h0000_000F); rdChk("R2 msk", 5'h0B, mMsk);
    wr(5'h0C, 32'hC000_0003); wr(5'h0D, 32'h4000_0000); rdChk("R2 od", 5'h0E, mOd);
    wr(5'h01, 32'h0); rdChk("R2 zero clr no effect", 5'h02, mOwn);

    // R3: masked direct write, including mask zero
    wr(5'h08, 32'hFFFF_0000); rdChk("R3 masked write", 5'h08, mDat);
    wr(5'h08, 32'h0000_FFFF); rdChk("R3 masked write b", 5'h08, mDat);
    wr(5'h0A, 32'hFFFF_FFFF); v = mDat;
    wr(5'h08, ~v); rdChk("R3 mask zero no effect", 5'h08, v);

    // R7: selection registers and write-only reads
    wr(5'h0F, 32'h1234_5678); wr(5'h10, 32'h9ABC_DEF0);
    rdChk("R7 sel lo", 5'h0F, 32'h1234_5678);
    rdChk("R7 sel hi", 5'h10, 32'h9ABC_DEF0);
    for (int a = 0; a < 32; a++)
      if (a inside {0, 1, 3, 4, 6, 7, 9, 10, 12, 13} || a > 17)
        rdChk("R7 write-only reads 0", 5'(a), '0);
    busAddr = 5'h0F; #1 chk("R7 rdEn low", busRdData, '0);

    // R4/R6: sweep of ownership, codes, open-drain and data patterns
    for (int k = 0; k < 16; k++) begin
      periphDout[0] = 32'hA5A5_0F0F ^ {8{4'(k)}};
      periphDout[1] = 32'h3C3C_C3C3 + 32'(k * 7);
      periphDout[2] = ~periphDout[0];
      periphDout[3] = 32'h00FF_FF00 ^ 32'(k << 3);
      periphOe[0] = 32'hFFFF_0000 >> k;
      periphOe[1] = 32'h0F0F_F0F0 ^ 32'(k);
      periphOe[2] = 32'hCCCC_3333;
      periphOe[3] = ~periphOe[1];
      wr(5'h0F, 32'hAAAA_AAAA ^ {8{4'(k)}});
      wr(5'h10, 32'hCCCC_CCCC ^ {4{8'(k * 3)}});
      wr(5'h00, 32'h0101_0101 << (k % 8)); wr(5'h01, 32'h1010_1010 << (k % 4));
      wr(5'h03, 32'h5555_5555 ^ 32'(k)); wr(5'h04, 32'h0000_F000 >> (k % 8));
      wr(5'h06, 32'h6969_9696 ^ 32'(k << 5)); wr(5'h07, 32'h0003_0003 << k);
      wr(5'h0C, (k % 2 == 1) ? 32'hFF00_FF00 : 32'h0F0F_0F0F);
      wr(5'h0D, (k % 3 == 0) ? 32'hFFFF_0000 : 32'h0000_0001);
      padChk("R4 R6 sweep");
    end

    // R5: configure while peripheral owns, then take over
    wr(5'h01, 32'hFFFF_FFFF); wr(5'h0D, 32'hFFFF_FFFF);
    wr(5'h04, 32'hFFFF_FFFF); wr(5'h07, 32'hFFFF_FFFF);
    wr(5'h03, 32'h00FF_00FF); wr(5'h06, 32'h0F0F_0F0F);
    rdChk("R5 oe stored", 5'h05, 32'h00FF_00FF);
    rdChk("R5 dat stored", 5'h08, 32'h0F0F_0F0F);
    padChk("R5 peripheral still drives");
    wr(5'h00, 32'hFFFF_FFFF);
    chk("R5 takeover padOut", padOut, 32'h0F0F_0F0F);
    chk("R5 takeover padOe", padOe, 32'h00FF_00FF);
    wr(5'h0C, 32'hFFFF_FFFF);
    chk("R6 od padOut", padOut, '0);
    chk("R6 od padOe", padOe, 32'h00F0_00F0);

    // R8: two-flop synchronizer
    for (int k = 0; k < 4; k++) begin
      logic [NP-1:0] prev, nxt;
      prev = padIn; nxt = 32'hDEAD_BEEF ^ 32'(k * 32'h1111_1111);
      @(negedge clk); padIn = nxt;
      @(negedge clk); rdChk("R8 one edge old", 5'h11, prev);
      @(negedge clk); rdChk("R8 two edges new", 5'h11, nxt);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule